// File: doc/BRIEF.md
# Request-Paced Word DMA Channel (Memory to Peripheral)

This block is one DMA channel that feeds a peripheral's transmit FIFO from memory, one 32-bit word at a time. Software writes a word-aligned source byte address, a length counted in words, and a control word holding a channel enable, a direction select, an interrupt mask and a write-one-to-clear done flag. A separate global enable input must also be high before the channel does anything. While the channel is running, each request pulse from the peripheral starts a single read on a simple valid/ready memory port. The word returned on the handshake cycle is written straight into the peripheral on that same cycle.

After every word the address advances by four bytes and the remaining length drops by one. When the length reaches zero the channel turns off its own enable, ignores further requests, and sets a sticky done flag. The interrupt output is that flag gated by the mask bit. A length of zero programmed with the channel enabled finishes at once, without touching memory. Only the memory-to-I/O direction is implemented: with the direction bit at 1 the channel stays idle.

Top module: `wordpump_dma`

## Requirements
- R1: After reset the source address, the length and all control bits read as zero, `irq` is low, and `mem_valid` and `per_we` are low.
- R2: The source address ignores the two low bits of the written value. They read back as zero, and `mem_addr[1:0]` is always zero.
- R3: A request (`per_req` high on a clock edge while the channel is idle, running and has a nonzero length) raises `mem_valid` from the next cycle onward, with `mem_addr` equal to the current source address. Both stay unchanged until the cycle in which `mem_ready` is high.
- R4: In the cycle where `mem_valid` and `mem_ready` are both high, `per_we` is high and `per_wdata` equals `mem_rdata`. Exactly one word moves per accepted request.
- R5: Each moved word adds 4 to the source address and subtracts 1 from the length. Both are visible on the register read port (`rd_sel` 0 selects the address, 1 the length, 2 the control word).
- R6: Requests have no effect while the channel enable (control bit 0) is 0, while `glb_en` is 0, or while the direction bit (control bit 1) is 1.
- R7: When the last word moves, the enable bit clears and the done flag (control bit 3) sets. Later requests move no words.
- R8: `irq` equals the done flag ANDed with the mask bit (control bit 2).
- R9: Writing the control word with bit 3 set clears the done flag. Bits 0 to 2 of that write load enable, direction and mask.
- R10: With the channel enabled, `glb_en` high, direction 0 and a length of zero, the done flag sets and the enable clears on the next clock edge, with no memory read.
- R11: Requests that arrive while a read is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global master enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 address, 1 length, 2 control |
| cfg_wdata | input | 32 | Register write data |
| rd_sel | input | 2 | Read port select |
| rd_data | output | 32 | Selected register value |
| per_req | input | 1 | Peripheral word request |
| per_we | output | 1 | Peripheral FIFO write strobe |
| per_wdata | output | 32 | Word written to the peripheral |
| mem_valid | output | 1 | Memory read request |
| mem_addr | output | AW | Memory byte address |
| mem_ready | input | 1 | Memory read data is valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The bench varies memory latency from zero-wait to several wait cycles. A design that dropped `mem_valid` early, or moved its address before the handshake, would then show a mismatched `mem_addr` or a lost word. It sends extra request pulses during an outstanding read, and after the final word. A design that queued those pulses would move too many words and wrap the length below zero. It also covers a zero length, which must finish without a read rather than underflowing into a huge transfer, and each of the three gating conditions on its own. The interrupt is checked with the mask both set and clear, so that a raw done flag driven onto `irq` is caught.

// File: rtl/wordpump_dma.sv
module wordpump_dma #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic [1:0]    rd_sel,
  output logic [31:0]   rd_data,
  input  logic          per_req,
  output logic          per_we,
  output logic [31:0]   per_wdata,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  localparam int WW = AW - 2;

  typedef enum logic {S_IDLE, S_READ} st_t;

  st_t           st_q;
  logic [WW-1:0] waddr_q;
  logic [CW-1:0] cnt_q;
  logic          en_q, dir_q, mask_q, done_q;

  logic run, idle, start, zero_done, beat, last, ctl_wr;

  assign run       = en_q & glb_en & ~dir_q;
  assign idle      = (st_q == S_IDLE);
  assign start     = idle & run & per_req & (cnt_q != '0);
  assign zero_done = idle & run & (cnt_q == '0);
  assign beat      = (st_q == S_READ) & mem_ready;
  assign last      = beat & (cnt_q == CW'(1));
  assign ctl_wr    = cfg_we & (cfg_sel == 2'd2);

  assign mem_valid = (st_q == S_READ);
  assign mem_addr  = {waddr_q, 2'b00};
  assign per_we    = beat;
  assign per_wdata = mem_rdata;
  assign irq       = done_q & mask_q;

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = 32'({waddr_q, 2'b00});
      2'd1:    rd_data = 32'(cnt_q);
      2'd2:    rd_data = {28'd0, done_q, mask_q, dir_q, en_q};
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      waddr_q <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      mask_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (start) st_q <= S_READ;
      else if (beat) st_q <= S_IDLE;

      if (beat) begin
        waddr_q <= waddr_q + WW'(1);
        cnt_q   <= cnt_q - CW'(1);
      end
      if (last | zero_done) en_q <= 1'b0;

      if (cfg_we && cfg_sel == 2'd0) waddr_q <= cfg_wdata[AW-1:2];
      if (cfg_we && cfg_sel == 2'd1) cnt_q   <= cfg_wdata[CW-1:0];
      if (ctl_wr) begin
        en_q   <= cfg_wdata[0];
        dir_q  <= cfg_wdata[1];
        mask_q <= cfg_wdata[2];
      end

      if (ctl_wr && cfg_wdata[3]) done_q <= 1'b0;
      if (last | zero_done) done_q <= 1'b1;
    end
  end
endmodule

module wordpump_dma_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glb_en,
  input logic          cfg_we,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          per_we,
  input logic [CW-1:0] cnt_q,
  input logic          en_q,
  input logic          dir_q,
  input logic          done_q
);
  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[1:0] == 2'b00);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  assert_one_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_we && !cfg_we |=> cnt_q == $past(cnt_q) - CW'(1));

  assert_last_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    per_we && cnt_q == CW'(1) && !cfg_we |=> !en_q && done_q);

  assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en && !mem_valid |=> !mem_valid);

  assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && glb_en && !dir_q && cnt_q == '0 && !mem_valid && !cfg_we
    |=> done_q && !en_q && !mem_valid);
endmodule

bind wordpump_dma wordpump_dma_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cfg_we(cfg_we),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .per_we(per_we), .cnt_q(cnt_q), .en_q(en_q), .dir_q(dir_q), .done_q(done_q)
);

// File: tb/wordpump_dma_bench.sv
`timescale 1ns/1ps
module wordpump_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        per_req = 1'b0;
  logic        per_we;
  logic [31:0] per_wdata;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic        mem_ready;
  logic [31:0] mem_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  wordpump_dma u_wordpump_dma (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_sel(rd_sel),
    .rd_data(rd_data), .per_req(per_req), .per_we(per_we),
    .per_wdata(per_wdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  int words  = 0;
  int lat    = 0;

  logic [31:0] m_addr = '0;
  logic [15:0] m_cnt  = '0;
  logic        m_en = 1'b0, m_dir = 1'b0, m_mask = 1'b0, m_done = 1'b0, m_busy = 1'b0;
  int          wcnt = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h1357_2468;
  endfunction

  assign mem_ready = m_busy && (wcnt >= lat);
  assign mem_rdata = pat(m_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [31:0] a;
    logic [15:0] c;
    logic e, d, k, dn, b, fin, rdy;
    int w;
    if (!rst_n) begin
      m_addr <= '0; m_cnt <= '0; m_en <= 0; m_dir <= 0; m_mask <= 0;
      m_done <= 0; m_busy <= 0; wcnt <= 0;
    end else begin
      a = m_addr; c = m_cnt; e = m_en; d = m_dir; k = m_mask; dn = m_done;
      b = m_busy; w = wcnt; fin = 0;
      rdy = m_busy && (wcnt >= lat);
      if (per_we) words++;
      if (m_busy) begin
        if (rdy) begin
          a = a + 4; c = c - 1; b = 0; w = 0;
          if (c == 0) begin e = 0; fin = 1; end
        end else w++;
      end else if (m_en && glb_en && !m_dir) begin
        if (m_cnt == 0) begin e = 0; fin = 1; end
        else if (per_req) begin b = 1; w = 0; end
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: a = cfg_wdata & 32'hFFFF_FFFC;
          2'd1: c = cfg_wdata[15:0];
          2'd2: begin
            e = cfg_wdata[0]; d = cfg_wdata[1]; k = cfg_wdata[2];
            if (cfg_wdata[3]) dn = 0;
          end
          default: ;
        endcase
      end
      if (fin) dn = 1;
      m_addr <= a; m_cnt <= c; m_en <= e; m_dir <= d; m_mask <= k;
      m_done <= dn; m_busy <= b; wcnt <= w;
    end
  end

  always @(negedge clk) begin
    logic [31:0] erd;
    #1;
    chk("R3 mem_valid", {31'd0, mem_valid}, {31'd0, m_busy});
    if (m_busy) chk("R3 mem_addr", mem_addr, m_addr);
    chk("R4 per_we", {31'd0, per_we}, {31'd0, mem_ready});
    if (mem_ready) chk("R4 per_wdata", per_wdata, pat(m_addr));
    chk("R8 irq", {31'd0, irq}, {31'd0, m_done & m_mask});
    case (rd_sel)
      2'd0: erd = m_addr;
      2'd1: erd = {16'd0, m_cnt};
      2'd2: erd = {28'd0, m_done, m_mask, m_dir, m_en};
      default: erd = '0;
    endcase
    chk("R5 readback", rd_data, erd);
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input string tag, input logic [1:0] s, input logic [31:0] exp);
    @(negedge clk); rd_sel = s; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse;
    @(negedge clk); per_req = 1;
    @(negedge clk); per_req = 0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rd("R1 reset addr", 2'd0, 32'd0);
    rd("R1 reset count", 2'd1, 32'd0);
    rd("R1 reset ctrl", 2'd2, 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1;
    glb_en = 1;

    wr(2'd0, 32'h1000_0013);
    rd("R2 aligned addr", 2'd0, 32'h1000_0010);
    wr(2'd1, 32'd5);
    wr(2'd2, 32'h5);
    for (int i = 0; i < 5; i++) begin
      lat = i % 4;
      pulse();
      wait_idle();
      repeat (i) @(negedge clk);
    end
    rd("R5 addr after 5 words", 2'd0, 32'h1000_0024);
    rd("R5 count after 5 words", 2'd1, 32'd0);
    rd("R7 ctrl done, en cleared", 2'd2, 32'hC);
    chk("R8 irq after done", {31'd0, irq}, 32'd1);
    chk("R4 five words moved", words, 5);
    w0 = words;
    pulse(); pulse();
    repeat (3) @(negedge clk);
    chk("R7 no words after done", words, w0);

    wr(2'd2, 32'hC);
    rd("R9 done cleared", 2'd2, 32'h4);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);

    glb_en = 0;
    wr(2'd1, 32'd3);
    wr(2'd2, 32'h5);
    pulse(); pulse();
    repeat (2) @(negedge clk);
    chk("R6 global off", words, w0);
    rd("R6 count kept (global)", 2'd1, 32'd3);
    glb_en = 1;
    wr(2'd2, 32'h7);
    pulse();
    repeat (2) @(negedge clk);
    chk("R6 direction 1", words, w0);
    wr(2'd2, 32'h4);
    pulse();
    repeat (2) @(negedge clk);
    chk("R6 channel off", words, w0);
    rd("R6 count kept", 2'd1, 32'd3);

    wr(2'd1, 32'd0);
    wr(2'd2, 32'h5);
    repeat (2) @(negedge clk);
    rd("R10 zero length done", 2'd2, 32'hC);
    chk("R10 no word moved", words, w0);
    chk("R8 irq zero length", {31'd0, irq}, 32'd1);

    wr(2'd2, 32'hC);
    wr(2'd0, 32'h0000_2000);
    wr(2'd1, 32'd4);
    lat = 4;
    wr(2'd2, 32'h5);
    @(negedge clk); per_req = 1;
    @(negedge clk); per_req = 0;
    @(negedge clk); per_req = 1;
    @(negedge clk); per_req = 0;
    @(negedge clk); per_req = 1;
    @(negedge clk); per_req = 0;
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R11 one word per accepted request", words, w0 + 1);
    rd("R11 count after one word", 2'd1, 32'd3);

    lat = 0;
    @(negedge clk); per_req = 1;
    while (m_en || m_busy) @(negedge clk);
    per_req = 0;
    repeat (2) @(negedge clk);
    chk("R7 burst of requests stops at zero", words, w0 + 4);
    rd("R5 addr after second run", 2'd0, 32'h0000_2010);

    wr(2'd2, 32'h8);
    wr(2'd1, 32'd2);
    lat = 1;
    wr(2'd2, 32'h1);
    @(negedge clk); per_req = 1;
    while (m_en || m_busy) @(negedge clk);
    per_req = 0;
    repeat (2) @(negedge clk);
    rd("R8 done with mask clear", 2'd2, 32'h8);
    chk("R8 irq masked", {31'd0, irq}, 32'd0);

    summary();
    $finish;
  end
endmodule